// File: doc/BRIEF.md
# MAC Transmit Deferral Controller

This block decides the moment at which an Ethernet MAC transmitter may begin a frame. It watches carrier sense, receive activity, collision and the SQE-test indication, times the inter-packet gap and a post-transmit carrier blinding window, and grants a start with a single-cycle pulse. The serializer tells it when a frame has finished, and the block returns to waiting for the next start.

A duplex-mode input selects between two rule sets. With shared media (half duplex), the gap is measured from the end of all line activity and restarts whenever carrier or receive activity reappears. A blinding window follows every transmission, during which carrier sense is masked and the SQE test is sampled. Collisions abort a frame, and a frame sent without ever seeing carrier is reported as a loss of carrier. On a dedicated link (full duplex), the gap runs from the end of the block's own transmit. Line activity and collisions are ignored, no blinding window is inserted, and neither loss of carrier nor SQE status is ever produced.

The controller is built around four states. READY is idle with the gap satisfied. XMIT is a frame in flight. BLIND is the half-duplex masking window. GAP is the inter-packet gap count. The transitions are as follows:
- READY goes to XMIT on a granted request.
- READY goes to GAP when half-duplex line activity appears.
- XMIT goes to BLIND (half duplex) or GAP (full duplex) on frame end or a half-duplex collision.
- BLIND goes to GAP when the window expires.
- GAP goes to READY when the gap count expires without a restart.

Top module: `txdefer_ctrl`

## Requirements
- R1: After reset the block is in READY with every output low and half duplex latched, so a first request with an idle line is granted in the same cycle.
- R2: `tx_grant` is high for exactly one cycle per frame; the block then stays in XMIT until `tx_done` (or a half-duplex collision).
- R3: The gap length is GAP_FAST cycles when `speed_100` is 1 and GAP_SLOW cycles when it is 0, with the speed sampled only in READY. In full duplex a held request is granted exactly GAP cycles after the clock edge that sees `tx_done`.
- R4: In half duplex, a BLIND window of BLIND_CYC cycles follows each frame end before the gap starts. Carrier sense inside that window is ignored, so an idle line gives a grant BLIND_CYC+GAP cycles after frame end.
- R5: In half duplex, `crs` or `rx_active` high in the GAP state restarts the gap, so the grant follows the last busy clock edge by exactly GAP cycles. In READY, either signal blocks the grant.
- R6: In full duplex, neither `crs` nor `rx_active` delays or blocks a grant.
- R7: In half duplex, `col` during XMIT raises `coll_abort` in that cycle and ends the frame as `tx_done` would. In full duplex, `col` has no effect and `coll_abort` stays low.
- R8: In half duplex, `lcar_pulse` is high in the `tx_done` cycle when `crs` was low on every cycle of XMIT. In full duplex it is never raised.
- R9: In half duplex, `sqe_pulse` is high in the last cycle of the BLIND window if `sqe_in` was high on any cycle of that window. In full duplex it is never raised.
- R10: `full_duplex` is sampled only in READY. A change made during XMIT, BLIND or GAP applies neither to that frame nor to its gap.
- R11: `deferring` is high whenever `tx_req` is high, no grant is given and the block is not in XMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_req | input | 1 | A frame is waiting to be sent |
| tx_done | input | 1 | Serializer finished the current frame |
| crs | input | 1 | Carrier sense |
| rx_active | input | 1 | Receive in progress |
| col | input | 1 | Collision detected |
| sqe_in | input | 1 | SQE-test signal from the PHY |
| full_duplex | input | 1 | 1 selects full duplex, 0 half duplex |
| speed_100 | input | 1 | 1 selects 100 Mb/s gap, 0 selects 10 Mb/s gap |
| tx_grant | output | 1 | One-cycle permission to start a frame |
| deferring | output | 1 | A request is being held off |
| lcar_pulse | output | 1 | Loss-of-carrier status pulse |
| sqe_pulse | output | 1 | SQE-test status pulse |
| coll_abort | output | 1 | Frame ended by a collision |

## Verification
The bench builds the block with GAP_FAST = 6, GAP_SLOW = 20 and BLIND_CYC = 5, in place of the hundreds of cycles used for a 100 MHz clock. With these values every gap, restart and blinding window completes within a few dozen cycles. This makes it possible to measure the exact cycle of each grant and to compare the 5+6, 5+20, 6 and 20 cycle outcomes directly. The short window also lets the bench drive carrier entirely inside BLIND, straddle the BLIND-to-GAP boundary, and switch speed and duplex between frames to show when each setting is picked up.

// File: rtl/txd_pkg.sv
`timescale 1ns/1ps
package txd_pkg;
    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_XMIT  = 2'd1,
        ST_BLIND = 2'd2,
        ST_GAP   = 2'd3
    } txd_state_e;
endpackage

// File: rtl/txd_interval_cnt.sv
`timescale 1ns/1ps
// Up-counter shared by the blinding window and the gap timer.
module txd_interval_cnt #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == (limit - 1'b1));
endmodule

// File: rtl/txd_sticky.sv
`timescale 1ns/1ps
// Set/clear flag; clear wins over set.
module txd_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic set,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (clear) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end
    end
endmodule

// File: rtl/txdefer_ctrl.sv
`timescale 1ns/1ps
module txdefer_ctrl
    import txd_pkg::*;
#(
    parameter int GAP_SLOW  = 960,
    parameter int GAP_FAST  = 96,
    parameter int BLIND_CYC = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_req,
    input  logic tx_done,
    input  logic crs,
    input  logic rx_active,
    input  logic col,
    input  logic sqe_in,
    input  logic full_duplex,
    input  logic speed_100,
    output logic tx_grant,
    output logic deferring,
    output logic lcar_pulse,
    output logic sqe_pulse,
    output logic coll_abort
);
    localparam int SPAN_A   = (GAP_SLOW > GAP_FAST) ? GAP_SLOW : GAP_FAST;
    localparam int SPAN_MAX = (SPAN_A > BLIND_CYC) ? SPAN_A : BLIND_CYC;
    localparam int CNT_W    = $clog2(SPAN_MAX + 1);
    localparam logic [CNT_W-1:0] SLOW_LEN  = CNT_W'(GAP_SLOW);
    localparam logic [CNT_W-1:0] FAST_LEN  = CNT_W'(GAP_FAST);
    localparam logic [CNT_W-1:0] BLIND_LEN = CNT_W'(BLIND_CYC);

    txd_state_e       state_q;
    txd_state_e       state_d;
    logic             fdx_q;
    logic [CNT_W-1:0] gap_len_q;
    logic [CNT_W-1:0] cnt_limit;
    logic             line_busy;
    logic             mode_fdx;
    logic             frame_end;
    logic             gap_restart;
    logic             cnt_clear;
    logic             cnt_last;
    logic             crs_seen;
    logic             sqe_seen;

    // Mode in force: live input while idle, latched copy otherwise.
    assign line_busy   = crs | rx_active;
    assign mode_fdx    = (state_q == ST_READY) ? full_duplex : fdx_q;
    assign frame_end   = (state_q == ST_XMIT) && (tx_done || (!fdx_q && col));
    assign gap_restart = (state_q == ST_GAP) && !fdx_q && line_busy;
    assign cnt_limit   = (state_q == ST_BLIND) ? BLIND_LEN : gap_len_q;

    // Next-state decode.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: begin
                if (!mode_fdx && line_busy) begin
                    state_d = ST_GAP;
                end else if (tx_req) begin
                    state_d = ST_XMIT;
                end
            end
            ST_XMIT: begin
                if (frame_end) begin
                    state_d = fdx_q ? ST_GAP : ST_BLIND;
                end
            end
            ST_BLIND: begin
                if (cnt_last) begin
                    state_d = ST_GAP;
                end
            end
            ST_GAP: begin
                if (!gap_restart && cnt_last) begin
                    state_d = ST_READY;
                end
            end
            default: state_d = ST_READY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_READY;
        end else begin
            state_q <= state_d;
        end
    end

    // Duplex and gap length are captured only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fdx_q     <= 1'b0;
            gap_len_q <= SLOW_LEN;
        end else if (state_q == ST_READY) begin
            fdx_q     <= full_duplex;
            gap_len_q <= speed_100 ? FAST_LEN : SLOW_LEN;
        end
    end

    // Outputs and counter control.
    always_comb begin
        tx_grant   = (state_q == ST_READY) && tx_req && (mode_fdx || !line_busy);
        deferring  = tx_req && !tx_grant && (state_q != ST_XMIT);
        coll_abort = (state_q == ST_XMIT) && !fdx_q && col;
        lcar_pulse = (state_q == ST_XMIT) && !fdx_q && tx_done && !col
                     && !crs && !crs_seen;
        sqe_pulse  = (state_q == ST_BLIND) && cnt_last && (sqe_seen || sqe_in);
        cnt_clear  = !(state_q inside {ST_BLIND, ST_GAP})
                     || (state_d != state_q) || gap_restart;
    end

    txd_interval_cnt #(.CNT_W(CNT_W)) u_interval (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .limit (cnt_limit),
        .last  (cnt_last)
    );

    txd_sticky u_crs_seen (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tx_grant),
        .set   ((state_q == ST_XMIT) && crs),
        .flag  (crs_seen)
    );

    txd_sticky u_sqe_seen (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q != ST_BLIND),
        .set   ((state_q == ST_BLIND) && sqe_in),
        .flag  (sqe_seen)
    );
endmodule

// File: rtl/txd_checker.sv
`timescale 1ns/1ps
module txd_checker
    import txd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input txd_state_e state_q,
    input logic       fdx_q,
    input logic       full_duplex,
    input logic       crs,
    input logic       rx_active,
    input logic       tx_grant,
    input logic       deferring,
    input logic       lcar_pulse,
    input logic       sqe_pulse,
    input logic       coll_abort
);
    a_r2_grant_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant |=> !tx_grant);

    a_r5_half_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_grant && !full_duplex) |-> !(crs || rx_active));

    a_r7_full_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        fdx_q |-> !coll_abort);

    a_r8_full_no_lcar: assert property (@(posedge clk) disable iff (!rst_n)
        fdx_q |-> !lcar_pulse);

    a_r9_full_no_sqe: assert property (@(posedge clk) disable iff (!rst_n)
        fdx_q |-> !sqe_pulse);

    a_r10_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_READY) |=> $stable(fdx_q));

    a_r11_defer_vs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        tx_grant |-> !deferring);

    a_r4_no_grant_in_blind: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLIND) |-> !tx_grant);
endmodule

bind txdefer_ctrl txd_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_q     (state_q),
    .fdx_q       (fdx_q),
    .full_duplex (full_duplex),
    .crs         (crs),
    .rx_active   (rx_active),
    .tx_grant    (tx_grant),
    .deferring   (deferring),
    .lcar_pulse  (lcar_pulse),
    .sqe_pulse   (sqe_pulse),
    .coll_abort  (coll_abort)
);

// File: tb/test_txdefer_ctrl.sv
`timescale 1ns/1ps
module test_txdefer_ctrl;
    localparam int P_SLOW  = 20;
    localparam int P_FAST  = 6;
    localparam int P_BLIND = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_req = 1'b0, tx_done = 1'b0, crs = 1'b0, rx_active = 1'b0;
    logic col = 1'b0, sqe_in = 1'b0, full_duplex = 1'b0, speed_100 = 1'b1;
    logic tx_grant, deferring, lcar_pulse, sqe_pulse, coll_abort;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    txdefer_ctrl #(.GAP_SLOW(P_SLOW), .GAP_FAST(P_FAST), .BLIND_CYC(P_BLIND)) i_txdefer_ctrl (
        .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_done(tx_done), .crs(crs),
        .rx_active(rx_active), .col(col), .sqe_in(sqe_in), .full_duplex(full_duplex),
        .speed_100(speed_100), .tx_grant(tx_grant), .deferring(deferring),
        .lcar_pulse(lcar_pulse), .sqe_pulse(sqe_pulse), .coll_abort(coll_abort)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R1 / R2: reset state and the very first grant.
    task automatic t_reset_first();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1", "grant after reset", tx_grant, 0);
        chk("R1", "deferring after reset", deferring, 0);
        chk("R1", "status after reset", lcar_pulse | sqe_pulse | coll_abort, 0);
        tx_req = 1'b1;
        #1;
        chk("R1", "immediate first grant", tx_grant, 1);
        @(negedge clk);
        tx_req = 1'b0;
        crs = 1'b1;
        #1;
        chk("R2", "grant is one cycle", tx_grant, 0);
    endtask

    // End the current frame, hold a request and measure cycles to the next grant.
    task automatic t_end_measure(input string tag, input bit by_col, input int crs_hold,
                                 input int rx_hold, input int sqe_at, input int exp_gap,
                                 input int exp_sqe_k, input bit exp_lcar,
                                 input bit exp_abort, input bit frame_crs);
        int k;
        int sqe_k;
        @(negedge clk);
        if (by_col) col = 1'b1; else tx_done = 1'b1;
        #1;
        chk("R8", {tag, " lcar at frame end"}, lcar_pulse, exp_lcar);
        chk("R7", {tag, " collision abort"}, coll_abort, exp_abort);
        @(negedge clk);
        tx_done = 1'b0;
        col = 1'b0;
        tx_req = 1'b1;
        k = 0;
        sqe_k = -1;
        forever begin
            crs = (k < crs_hold);
            rx_active = (k < rx_hold);
            sqe_in = (k == sqe_at);
            #1;
            if (sqe_pulse) sqe_k = k;
            if (k == 1) chk("R11", {tag, " deferring while held"}, deferring, 1);
            if (tx_grant || k >= 200) break;
            @(negedge clk);
            k++;
        end
        chk("R3", {tag, " cycles to grant"}, k, exp_gap);
        chk("R9", {tag, " sqe pulse cycle"}, sqe_k, exp_sqe_k);
        @(negedge clk);
        tx_req = 1'b0;
        crs = frame_crs;
        rx_active = 1'b0;
        sqe_in = 1'b0;
        #1;
        chk("R2", {tag, " grant dropped"}, tx_grant, 0);
    endtask

    task automatic t_full_col_ignored();
        @(negedge clk);
        col = 1'b1;
        #1;
        chk("R7", "full-duplex col no abort", coll_abort, 0);
        @(negedge clk);
        col = 1'b0;
        #1;
        chk("R7", "full-duplex stays in frame", deferring | tx_grant, 0);
    endtask

    initial begin
        t_reset_first();
        // R4: half duplex, idle line: window plus gap.
        t_end_measure("R4 half idle", 0, 0, 0, -1, P_BLIND + P_FAST, -1, 0, 0, 1);
        // R4: carrier only inside the blinding window is ignored.
        t_end_measure("R4 crs in blind", 0, 3, 0, -1, P_BLIND + P_FAST, -1, 0, 0, 1);
        // R5: carrier into the gap restarts it.
        t_end_measure("R5 crs restart", 0, 8, 0, -1, 8 + P_FAST, -1, 0, 0, 1);
        // R5: receive activity restarts it too; next frame sees no carrier.
        t_end_measure("R5 rx restart", 0, 0, 9, -1, 9 + P_FAST, -1, 0, 0, 0);
        // R8 + R9: loss of carrier and SQE inside the window.
        t_end_measure("R8 R9 half status", 0, 0, 0, 2, P_BLIND + P_FAST, P_BLIND - 1, 1, 0, 1);
        // R10: duplex change during a frame not applied; R7 collision aborts.
        full_duplex = 1'b1;
        t_end_measure("R7 R10 half col", 1, 0, 0, -1, P_BLIND + P_FAST, -1, 0, 1, 0);
        // Now full duplex; speed change during frame applies to the next gap only.
        speed_100 = 1'b0;
        t_full_col_ignored();
        // R6: line activity ignored; R8/R9 never reported in full duplex.
        t_end_measure("R3 R6 full fast", 0, 3, 4, 2, P_FAST, -1, 0, 0, 1);
        // R10: switch back to half during the frame; gap still full-duplex slow.
        full_duplex = 1'b0;
        t_end_measure("R3 R6 R10 full slow", 0, 10, 0, -1, P_SLOW, -1, 0, 0, 1);
        // R3: half duplex at the slow speed.
        t_end_measure("R3 half slow", 0, 0, 0, -1, P_BLIND + P_SLOW, -1, 0, 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule